// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the register front end of a multi-channel DMA controller. It serves up to 32 channels and holds a global control word and four per-channel bitmaps: request enable, error-interrupt enable, interrupt flags and error flags. Software reaches all of them over a simple single-cycle bus with byte strobes. The block also decides which channel the transfer engine serves next.

Software can change one channel's bit without a read-modify-write. It writes the channel number as a single byte to a dedicated command address. Each command byte changes one bit: it sets or clears a request enable or an error-interrupt enable, clears an interrupt or an error flag, starts a channel, or clears a done status. The transfer engine sets the flags from hardware. The block ORs the flags into an interrupt line and an error line.

An arbiter looks at the channels whose hardware request is present and whose request enable is set. It grants one of them, either by fixed priority or by round robin. The grant is held until the engine reports that it is done. A halt bit and a stop-on-error bit can hold back new grants.

Top module: `chreg_bank`

## Requirements
- R1: After a synchronous active-low reset, the control word, all four bitmaps, `irq`, `err_irq`, `start_pulse`, `done_clr` and `grant_valid` are zero.
- R2: The control word sits at byte address 0x00. Only bits 1 to 7, 16 and 17 can be written and read back; all other bits read as zero. Only the bytes whose strobe is set are changed.
- R3: The request-enable bitmap sits at 0x0C and the error-interrupt-enable bitmap at 0x14. Both are written per byte strobe. Writes to the interrupt-flag bitmap (0x24) and the error-flag bitmap (0x2C) have no effect.
- R4: Each command byte names a channel in its bits 4:0; bits 7:5 are ignored. Byte 0x18 clears and byte 0x19 sets that channel's error-interrupt enable. Byte 0x1A clears and byte 0x1B sets its request enable.
- R5: A one on `hw_int_set` or `hw_err_set` sets the matching flag. Byte 0x1F clears one interrupt flag and byte 0x1E clears one error flag. When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: A write to byte 0x1D raises `start_pulse` for the named channel, and a write to byte 0x1C raises `done_clr` for the named channel. Each pulse is high for exactly the one cycle that follows the write.
- R7: `irq` is the OR of all interrupt flags. `err_irq` is the OR of the error flags whose error-interrupt enable is set.
- R8: With control bit 2 clear, the arbiter grants the highest-numbered channel that has both `hw_req` and its request enable set.
- R9: With control bit 2 set, the arbiter grants the first such channel found by counting upward, with wrap, from the channel after the one granted last.
- R10: A grant appears one clock after the arbiter decides, and `grant_ch` stays stable until a cycle in which `grant_done` is high. `grant_valid` is then low for at least one cycle before the next grant.
- R11: While control bit 5 (halt) is set, no new grant is issued. A grant that is already active stays active.
- R12: While control bit 4 (stop on error) is set and any error flag is set, no new grant is issued.
- R13: When `big_endian` is high, the byte at offset k of a word travels on `bus_wdata`/`bus_rdata` bits [8*(3-k)+7 : 8*(3-k)] with strobe `bus_be[3-k]`. When `big_endian` is low, byte k uses lane k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_endian | input | 1 | Selects reversed byte-lane order on the bus |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word-aligned byte address |
| bus_be | input | 4 | Byte strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; zero when not reading |
| hw_req | input | N_CH | Per-channel hardware request |
| hw_int_set | input | N_CH | Per-channel interrupt flag set |
| hw_err_set | input | N_CH | Per-channel error flag set |
| grant_done | input | 1 | Engine finished the granted channel |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | CH_W | Granted channel number |
| start_pulse | output | N_CH | One-cycle software start per channel |
| done_clr | output | N_CH | One-cycle done-clear per channel |
| irq | output | 1 | Any interrupt flag set |
| err_irq | output | 1 | Any enabled error flag set |

## Verification
The arbiter is driven with one fixed set of three pending channels (3, 9 and 20) under both priority modes. In fixed priority, channel 20 wins every time. In round robin, the grants cycle through 3, 9 and 20, which separates the two modes and shows the wrap-around. The command ports are tried with bytes whose upper three bits are non-zero, with the lowest and highest channel numbers, and in both lane orders. A same-cycle hardware set and software clear on one flag shows which side wins. Halt and stop-on-error are each applied while a grant is active and while the arbiter is idle, which tells blocking a new grant apart from aborting a current one.

// File: rtl/chreg_pkg.sv
// Shared constants for the channel register bank: byte addresses, control
// bit positions, command byte order and byte-lane helpers.
// Assumes a 32-bit data bus and at most 32 channels.
package chreg_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned LANES  = DATA_W / 8;

    // word addresses (byte addressed, word aligned)
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] A_REQEN  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_ERRIE  = 6'h14;
    localparam logic [ADDR_W-1:0] A_CMD_LO = 6'h18;
    localparam logic [ADDR_W-1:0] A_CMD_HI = 6'h1C;
    localparam logic [ADDR_W-1:0] A_INTF   = 6'h24;
    localparam logic [ADDR_W-1:0] A_ERRF   = 6'h2C;

    // control word bit positions
    localparam int unsigned CTL_DBG_STALL  = 1;
    localparam int unsigned CTL_ROUND_ROB  = 2;
    localparam int unsigned CTL_GROUP_RR   = 3;
    localparam int unsigned CTL_STOP_ERR   = 4;
    localparam int unsigned CTL_HALT       = 5;
    localparam int unsigned CTL_CONT_LINK  = 6;
    localparam int unsigned CTL_MINOR_OFS  = 7;
    localparam int unsigned CTL_ERR_CANCEL = 16;
    localparam int unsigned CTL_CANCEL     = 17;

    localparam logic [DATA_W-1:0] CTL_WMASK =
        (32'd1 << CTL_DBG_STALL) | (32'd1 << CTL_ROUND_ROB) |
        (32'd1 << CTL_GROUP_RR)  | (32'd1 << CTL_STOP_ERR)  |
        (32'd1 << CTL_HALT)      | (32'd1 << CTL_CONT_LINK) |
        (32'd1 << CTL_MINOR_OFS) | (32'd1 << CTL_ERR_CANCEL) |
        (32'd1 << CTL_CANCEL);

    // command kinds, ordered by byte offset from A_CMD_LO
    typedef enum logic [2:0] {
        CMD_EIE_CLR  = 3'd0,
        CMD_EIE_SET  = 3'd1,
        CMD_REQ_CLR  = 3'd2,
        CMD_REQ_SET  = 3'd3,
        CMD_DONE_CLR = 3'd4,
        CMD_START    = 3'd5,
        CMD_ERR_CLR  = 3'd6,
        CMD_INT_CLR  = 3'd7
    } cmd_e;

    localparam int unsigned N_CMD = 8;

    // reverse byte order of a data word
    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            r[8*l +: 8] = d[8*(LANES-1-l) +: 8];
        end
        return r;
    endfunction

    // reverse strobe order
    function automatic logic [LANES-1:0] swap_strobes(input logic [LANES-1:0] b);
        logic [LANES-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            r[l] = b[LANES-1-l];
        end
        return r;
    endfunction

    // replace the strobed bytes of old_v with new_v
    function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic [LANES-1:0]  be);
        logic [DATA_W-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            r[8*l +: 8] = be[l] ? new_v[8*l +: 8] : old_v[8*l +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/chreg_cmd_decode.sv
// Bus write decoder: brings data and strobes into little-endian lane order
// and turns writes into register write enables and per-channel command masks.
// Assumes word-aligned addresses; channel numbers at or above N_CH hit nothing.
module chreg_cmd_decode
    import chreg_pkg::*;
#(
    parameter int unsigned N_CH = 32
) (
    input  logic                         big_endian,
    input  logic                         bus_sel,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [LANES-1:0]             bus_be,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [LANES-1:0]             le_be,
    output logic [DATA_W-1:0]            le_wdata,
    output logic                         wr_ctrl,
    output logic                         wr_reqen,
    output logic                         wr_errie,
    output logic [N_CMD-1:0][N_CH-1:0]   cmd_hit
);

    logic wr;

    // lane reordering for the selected byte order
    assign le_be    = big_endian ? swap_strobes(bus_be) : bus_be;
    assign le_wdata = big_endian ? swap_bytes(bus_wdata) : bus_wdata;

    // plain register write enables
    assign wr       = bus_sel && bus_we;
    assign wr_ctrl  = wr && (bus_addr == A_CTRL);
    assign wr_reqen = wr && (bus_addr == A_REQEN);
    assign wr_errie = wr && (bus_addr == A_ERRIE);

    // one command per byte of the two command words, one bit per channel
    for (genvar k = 0; k < N_CMD; k++) begin : g_cmd
        localparam int unsigned LANE = k % LANES;
        localparam logic [ADDR_W-1:0] WADDR = (k < LANES) ? A_CMD_LO : A_CMD_HI;
        logic       byte_hit;
        logic [4:0] ch_num;
        assign byte_hit = wr && (bus_addr == WADDR) && le_be[LANE];
        assign ch_num   = le_wdata[8*LANE +: 5];
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            assign cmd_hit[k][c] = byte_hit && (ch_num == 5'(c));
        end
    end

endmodule

// File: rtl/chreg_arbiter.sv
// Channel arbiter: picks one pending channel by fixed priority (highest
// number wins) or round robin (search starts after the last grant), and
// holds the grant until the engine reports done.
// Assumes N_CH is a power of two for the round-robin wrap.
module chreg_arbiter #(
    parameter int unsigned N_CH = 32,
    localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pending,
    input  logic            round_robin,
    input  logic            allow,
    input  logic            grant_done,
    output logic            grant_valid,
    output logic [CH_W-1:0] grant_ch
);

    logic [CH_W-1:0] last_q;
    logic [CH_W-1:0] fp_idx;
    logic [CH_W-1:0] rr_idx;
    logic            rr_hit;
    logic [CH_W-1:0] pick;

    // fixed priority: the highest pending index wins
    always_comb begin
        fp_idx = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (pending[i]) fp_idx = CH_W'(i);
        end
    end

    // round robin: first pending index after last_q, with wrap
    always_comb begin
        logic [CH_W-1:0] j;
        rr_hit = 1'b0;
        rr_idx = '0;
        j      = '0;
        for (int k = 1; k <= N_CH; k++) begin
            j = CH_W'((int'(last_q) + k) % N_CH);
            if (!rr_hit && pending[j]) begin
                rr_hit = 1'b1;
                rr_idx = j;
            end
        end
    end

    assign pick = round_robin ? rr_idx : fp_idx;

    // grant register: release on done, otherwise grant when allowed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_ch    <= '0;
            last_q      <= CH_W'(N_CH - 1);
        end else if (grant_valid) begin
            if (grant_done) grant_valid <= 1'b0;
        end else if (allow && (|pending)) begin
            grant_valid <= 1'b1;
            grant_ch    <= pick;
            last_q      <= pick;
        end
    end

endmodule

// File: rtl/chreg_bank.sv
// Channel request and status register bank: control word, enable and flag
// bitmaps, single-channel command bytes, interrupt outputs and a channel
// arbiter. Reads are combinational; all state updates on the rising edge.
// Assumes N_CH <= 32.
module chreg_bank
    import chreg_pkg::*;
#(
    parameter int unsigned N_CH = 32,
    localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [5:0]        bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_CH-1:0]   hw_req,
    input  logic [N_CH-1:0]   hw_int_set,
    input  logic [N_CH-1:0]   hw_err_set,
    input  logic              grant_done,
    output logic              grant_valid,
    output logic [CH_W-1:0]   grant_ch,
    output logic [N_CH-1:0]   start_pulse,
    output logic [N_CH-1:0]   done_clr,
    output logic              irq,
    output logic              err_irq
);

    logic [LANES-1:0]           le_be;
    logic [DATA_W-1:0]          le_wdata;
    logic                       wr_ctrl, wr_reqen, wr_errie;
    logic [N_CMD-1:0][N_CH-1:0] cmd_hit;

    logic [DATA_W-1:0] ctrl_q;
    logic [N_CH-1:0]   req_en_q;
    logic [N_CH-1:0]   errie_q;
    logic [N_CH-1:0]   intf_q;
    logic [N_CH-1:0]   errf_q;
    logic [DATA_W-1:0] le_rdata;
    logic              allow;

    chreg_cmd_decode #(.N_CH(N_CH)) u_dec (
        .big_endian (big_endian),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .le_be      (le_be),
        .le_wdata   (le_wdata),
        .wr_ctrl    (wr_ctrl),
        .wr_reqen   (wr_reqen),
        .wr_errie   (wr_errie),
        .cmd_hit    (cmd_hit)
    );

    // control word: strobed bytes, only defined bits kept
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= lane_merge(ctrl_q, le_wdata & CTL_WMASK, le_be);
    end

    // request enables: bitmap write or single-channel set/clear
    always_ff @(posedge clk) begin
        if (!rst_n)        req_en_q <= '0;
        else if (wr_reqen) req_en_q <= N_CH'(lane_merge(DATA_W'(req_en_q), le_wdata, le_be));
        else               req_en_q <= (req_en_q & ~cmd_hit[CMD_REQ_CLR]) | cmd_hit[CMD_REQ_SET];
    end

    // error-interrupt enables: bitmap write or single-channel set/clear
    always_ff @(posedge clk) begin
        if (!rst_n)        errie_q <= '0;
        else if (wr_errie) errie_q <= N_CH'(lane_merge(DATA_W'(errie_q), le_wdata, le_be));
        else               errie_q <= (errie_q & ~cmd_hit[CMD_EIE_CLR]) | cmd_hit[CMD_EIE_SET];
    end

    // flags: hardware set takes precedence over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intf_q <= '0;
            errf_q <= '0;
        end else begin
            intf_q <= (intf_q & ~cmd_hit[CMD_INT_CLR]) | hw_int_set;
            errf_q <= (errf_q & ~cmd_hit[CMD_ERR_CLR]) | hw_err_set;
        end
    end

    // one-cycle command pulses toward the transfer engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= '0;
            done_clr    <= '0;
        end else begin
            start_pulse <= cmd_hit[CMD_START];
            done_clr    <= cmd_hit[CMD_DONE_CLR];
        end
    end

    // read mux in little-endian lane order; command words read as zero
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  le_rdata = ctrl_q;
            A_REQEN: le_rdata = DATA_W'(req_en_q);
            A_ERRIE: le_rdata = DATA_W'(errie_q);
            A_INTF:  le_rdata = DATA_W'(intf_q);
            A_ERRF:  le_rdata = DATA_W'(errf_q);
            default: le_rdata = '0;
        endcase
    end

    // bus read data in the selected byte order
    assign bus_rdata = (bus_sel && !bus_we)
                     ? (big_endian ? swap_bytes(le_rdata) : le_rdata) : '0;

    // interrupt lines
    assign irq     = |intf_q;
    assign err_irq = |(errf_q & errie_q);

    // new grants held back by halt or by stop-on-error with a pending error
    assign allow = !ctrl_q[CTL_HALT] && !(ctrl_q[CTL_STOP_ERR] && (|errf_q));

    chreg_arbiter #(.N_CH(N_CH)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending     (hw_req & req_en_q),
        .round_robin (ctrl_q[CTL_ROUND_ROB]),
        .allow       (allow),
        .grant_done  (grant_done),
        .grant_valid (grant_valid),
        .grant_ch    (grant_ch)
    );

endmodule

// File: rtl/chreg_bank_chk.sv
// Property checker for the channel register bank, bound into every instance.
// Observes ports and a few internal registers; drives nothing.
module chreg_bank_chk #(
    parameter int unsigned N_CH = 32,
    localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] hw_req,
    input logic [N_CH-1:0] req_en_q,
    input logic [31:0]     ctrl_q,
    input logic [N_CH-1:0] hw_int_set,
    input logic            irq,
    input logic            grant_valid,
    input logic            grant_done,
    input logic [CH_W-1:0] grant_ch,
    input logic [N_CH-1:0] start_pulse,
    input logic [N_CH-1:0] done_clr
);

    logic [N_CH-1:0] pend_q;

    // pending set as seen by the arbiter at the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= hw_req & req_en_q;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!grant_valid && !irq));

    // R10
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_done) |=> (grant_valid && $stable(grant_ch)));

    // R10
    grant_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_done) |=> !grant_valid);

    // R8
    grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> pend_q[grant_ch]);

    // R11
    halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && ctrl_q[5]) |=> !grant_valid);

    // R5
    int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_int_set) |=> irq);

    // R6
    start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_pulse) && $onehot0(done_clr));

endmodule

bind chreg_bank chreg_bank_chk #(.N_CH(N_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_req      (hw_req),
    .req_en_q    (req_en_q),
    .ctrl_q      (ctrl_q),
    .hw_int_set  (hw_int_set),
    .irq         (irq),
    .grant_valid (grant_valid),
    .grant_done  (grant_done),
    .grant_ch    (grant_ch),
    .start_pulse (start_pulse),
    .done_clr    (done_clr)
);

// File: tb/chreg_bank_bench.sv
// Self-checking bench: a register vector table, then directed tests for
// flags, pulses, byte order, arbitration, halt and stop-on-error.
module chreg_bank_bench;

    localparam int unsigned N_CH = 32;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned N_VEC = 10;

    // {write addr, strobes, write data, read addr, expected, requirement}
    localparam logic [83:0] VEC [N_VEC] = '{
        {6'h00, 4'hF, 32'hFFFF_FFFF, 6'h00, 32'h0003_00FE, 4'd2},  // R2 mask
        {6'h00, 4'h1, 32'h0000_0000, 6'h00, 32'h0003_0000, 4'd2},  // R2 strobes
        {6'h0C, 4'h3, 32'hA5A5_A5A5, 6'h0C, 32'h0000_A5A5, 4'd3},  // R3
        {6'h14, 4'hF, 32'h8000_0001, 6'h14, 32'h8000_0001, 4'd3},  // R3
        {6'h18, 4'h8, 32'h1F00_0000, 6'h0C, 32'h8000_A5A5, 4'd4},  // R4 set req 31
        {6'h18, 4'h4, 32'h00E0_0000, 6'h0C, 32'h8000_A5A4, 4'd4},  // R4 clr req 0, top bits ignored
        {6'h18, 4'h2, 32'h0000_4300, 6'h14, 32'h8000_0009, 4'd4},  // R4 set eie 3
        {6'h18, 4'h1, 32'h0000_001F, 6'h14, 32'h0000_0009, 4'd4},  // R4 clr eie 31
        {6'h24, 4'hF, 32'hFFFF_FFFF, 6'h24, 32'h0000_0000, 4'd3},  // R3 flag write ignored
        {6'h00, 4'hF, 32'h0000_0000, 6'h00, 32'h0000_0000, 4'd2}   // R2
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             big_endian = 1'b0;
    logic             bus_sel = 1'b0;
    logic             bus_we = 1'b0;
    logic [5:0]       bus_addr = '0;
    logic [3:0]       bus_be = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [N_CH-1:0]  hw_req = '0;
    logic [N_CH-1:0]  hw_int_set = '0;
    logic [N_CH-1:0]  hw_err_set = '0;
    logic             grant_done = 1'b0;
    logic             grant_valid;
    logic [4:0]       grant_ch;
    logic [N_CH-1:0]  start_pulse;
    logic [N_CH-1:0]  done_clr;
    logic             irq;
    logic             err_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    chreg_bank #(.N_CH(N_CH)) u_chreg_bank (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_req(hw_req), .hw_int_set(hw_int_set), .hw_err_set(hw_err_set),
        .grant_done(grant_done), .grant_valid(grant_valid), .grant_ch(grant_ch),
        .start_pulse(start_pulse), .done_clr(done_clr),
        .irq(irq), .err_irq(err_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_grant();
        @(negedge clk);
        grant_done = 1'b1;
        @(posedge clk);
        #1;
        grant_done = 1'b0;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 err_irq", 32'(err_irq), 0);
        chk("R1 grant", 32'(grant_valid), 0);
        chk("R1 pulses", start_pulse | done_clr, 0);
        rd(6'h00, rv); chk("R1 ctrl", rv, 0);
        rd(6'h0C, rv); chk("R1 reqen", rv, 0);

        // register vector table: R2 R3 R4
        for (int i = 0; i < N_VEC; i++) begin
            logic [83:0] v;
            v = VEC[i];
            wr(v[83:78], v[77:74], v[73:42]);
            rd(v[41:36], rv);
            chk($sformatf("R%0d vec%0d", v[3:0], i), rv, v[35:4]);
        end

        // R5 / R7 flags; error-interrupt enables are ch0 and ch3
        hw_int_set = 32'h10; tick(); hw_int_set = '0;
        chk("R7 irq on flag", 32'(irq), 1);
        rd(6'h24, rv); chk("R5 int flag set", rv, 32'h10);
        hw_err_set = 32'h08; tick(); hw_err_set = '0;
        chk("R7 err_irq enabled", 32'(err_irq), 1);
        hw_err_set = 32'h40; tick(); hw_err_set = '0;
        wr(6'h1C, 4'h4, 32'h0003_0000);          // clear error ch3
        rd(6'h2C, rv); chk("R5 err clear one", rv, 32'h40);
        chk("R7 err_irq masked", 32'(err_irq), 0);
        hw_int_set = 32'h10;                     // same cycle as clear ch4
        wr(6'h1C, 4'h8, 32'h0400_0000);
        hw_int_set = '0;
        rd(6'h24, rv); chk("R5 set wins", rv, 32'h10);
        wr(6'h1C, 4'h8, 32'h0400_0000);
        rd(6'h24, rv); chk("R5 int clear", rv, 0);
        chk("R7 irq clear", 32'(irq), 0);

        // R6 pulses
        wr(6'h1C, 4'h2, 32'h0000_0C00);
        chk("R6 start", start_pulse, 32'h0000_1000);
        tick();
        chk("R6 start one cycle", start_pulse, 0);
        wr(6'h1C, 4'h1, 32'h0000_0002);
        chk("R6 done clear", done_clr, 32'h4);
        tick();
        chk("R6 done one cycle", done_clr, 0);

        // R13 byte order
        big_endian = 1'b1;
        wr(6'h0C, 4'hF, 32'h1122_3344);
        rd(6'h0C, rv); chk("R13 big readback", rv, 32'h1122_3344);
        big_endian = 1'b0;
        rd(6'h0C, rv); chk("R13 little view", rv, 32'h4433_2211);
        big_endian = 1'b1;
        wr(6'h18, 4'h1, 32'h0000_0005);          // byte 0x1B in big lane 0
        big_endian = 1'b0;
        rd(6'h0C, rv); chk("R13 big cmd lane", rv, 32'h4433_2231);

        // R8 fixed priority
        wr(6'h0C, 4'hF, 32'hFFFF_FFFF);
        hw_req = (32'd1 << 3) | (32'd1 << 9) | (32'd1 << 20);
        tick();
        chk("R8 grant valid", 32'(grant_valid), 1);
        chk("R8 highest wins", 32'(grant_ch), 20);
        // R10 hold and gap
        tick(); tick();
        chk("R10 hold", {31'd0, grant_valid}, 1);
        finish_grant();
        chk("R10 gap", 32'(grant_valid), 0);
        tick();
        chk("R8 fixed again", 32'(grant_ch), 20);

        // R9 round robin
        wr(6'h00, 4'h1, 32'h0000_0004);
        finish_grant(); tick();
        chk("R9 wrap to 3", 32'(grant_ch), 3);
        finish_grant(); tick();
        chk("R9 next 9", 32'(grant_ch), 9);
        finish_grant(); tick();
        chk("R9 next 20", 32'(grant_ch), 20);
        finish_grant(); tick();
        chk("R9 wrap again", 32'(grant_ch), 3);

        // R11 halt
        wr(6'h00, 4'h1, 32'h0000_0024);
        chk("R11 active kept", 32'(grant_valid), 1);
        finish_grant();
        tick(); tick(); tick();
        chk("R11 no new grant", 32'(grant_valid), 0);
        wr(6'h00, 4'h1, 32'h0000_0004);
        tick();
        chk("R11 resume", 32'(grant_valid), 1);
        chk("R11 resume ch", 32'(grant_ch), 9);

        // R12 stop on error; error flag ch6 still set
        wr(6'h00, 4'h1, 32'h0000_0030);
        finish_grant();
        wr(6'h00, 4'h1, 32'h0000_0010);
        tick(); tick(); tick();
        chk("R12 blocked", 32'(grant_valid), 0);
        wr(6'h1C, 4'h4, 32'h0006_0000);          // clear error ch6
        tick();
        chk("R12 released", 32'(grant_valid), 1);
        chk("R12 fixed ch", 32'(grant_ch), 20);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        tick();
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset grant", 32'(grant_valid), 0);
        rd(6'h0C, rv); chk("R1 reset reqen", rv, 0);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule